// File: doc/BRIEF.md
# NAND Sector Hamming Check and Single-Bit Repair

This block checks one 512-byte NAND sector against its stored Hamming code after a read. It takes the 32-bit raw parity word from a parity generator that ran over the sector, strips the unused nibbles, packs and inverts the rest into a 24-bit code, and XORs that with the 24-bit code read from the spare area. The resulting syndrome is sorted into one of four outcomes: clean, a data bit that can be repaired, a single flipped bit inside the stored code, or damage beyond repair.

If a data bit can be repaired, the block reports the byte offset and the bit mask. It then repairs the sector buffer in place through a byte-wide read-modify-write port: one read, one write of the read byte XOR the mask, then a done pulse. Every other outcome completes in one cycle and leaves the buffer untouched. Because the packed code is inverted, an erased sector (all data 0xFF, stored code all ones) gives a raw parity of zero and checks clean.

Top module: `nand_ecc_corrector`

## Requirements
- R1: After reset, status is 00, err_offset and err_mask are zero, and busy, done, buf_rd_en and buf_wr_en are low.
- R2: The computed code is the bitwise inverse of {raw_parity[27:16], raw_parity[11:0]}. Bits 31:28 and 15:12 of raw_parity have no effect on any result.
- R3: stored_ecc carries the stored code as three bytes, least significant first: byte 0 in bits 7:0, byte 1 in 15:8, byte 2 in 23:16. The syndrome is computed code XOR stored_ecc.
- R4: A zero syndrome gives status 00, with done high in the first cycle after the start cycle and no buffer access.
- R5: A syndrome whose bits 11:0 XOR bits 23:12 equal 0xFFF, and whose byte offset syndrome[23:15] is below SECTOR_BYTES, gives status 01, err_offset = syndrome[23:15] and err_mask = 1 << syndrome[14:12].
- R6: For status 01, buf_rd_en is high with buf_addr = offset in cycle 1 after start. buf_wr_en is high in cycle 2 at the same address, with buf_wdata = buf_rdata XOR mask. done is high in cycle 3. busy is high in cycles 1 and 2 only. buf_rdata is taken one cycle after the read strobe.
- R7: A syndrome that passes the complement test but has a byte offset of SECTOR_BYTES or more gives status 11 and no buffer access.
- R8: A nonzero syndrome that fails the complement test and has exactly one bit set gives status 10 (the stored code alone is damaged), with no buffer access.
- R9: Any other nonzero syndrome gives status 11, with no buffer access.
- R10: start is ignored while busy or done is high.
- R11: done is a single-cycle pulse. status, err_offset and err_mask hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to check the presented sector |
| raw_parity | input | 32 | Raw parity word from the generator, sampled with start |
| stored_ecc | input | 24 | Stored code bytes, byte 0 in bits 7:0, sampled with start |
| busy | output | 1 | Repair read-modify-write in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 clean, 01 data bit repaired, 10 code-only error, 11 uncorrectable |
| err_offset | output | 9 | Byte offset of the faulty bit |
| err_mask | output | 8 | One-hot mask of the faulty bit within the byte |
| buf_rd_en | output | 1 | Sector buffer read strobe |
| buf_wr_en | output | 1 | Sector buffer write strobe |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_wdata | output | 8 | Repaired byte to write |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after buf_rd_en |

## Verification
The assertions assume that the sector buffer returns read data exactly one cycle after the read strobe. They also assume that start is a clean strobe, sampled only while the block is idle. The bench models the buffer with that one-cycle read latency and drives start for a single cycle, one idle cycle after each done pulse, except in the case that deliberately strikes while busy. Syndromes are built in the bench from the intended outcome: complement pairs for every offset and bit, every single-bit code fault, and every two-bit fault. This keeps each stimulus in the class it is meant to exercise.

// File: rtl/nand_ecc_pkg.sv
// Shared types for the sector check and repair block.
// Assumes a two-bit status encoding visible at the top-level port.
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ECC_CLEAN      = 2'b00,
        ECC_DATA_FIXED = 2'b01,
        ECC_CODE_ONLY  = 2'b10,
        ECC_FAILED     = 2'b11
    } ecc_status_e;

endpackage

// File: rtl/ecc_code_pack.sv
// Packs the 32-bit raw parity register into the inverted code word.
// Assumes each half of the code sits in the low bits of its 16-bit
// register half; the upper bits of each half are reserved and dropped.
module ecc_code_pack #(
    parameter int HALF_W = 12
) (
    input  logic [31:0]         raw_parity,
    output logic [2*HALF_W-1:0] calc_code
);

    logic [2*HALF_W-1:0] packed_code;

    // One slice per register half, reserved upper bits discarded.
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign packed_code[h*HALF_W +: HALF_W] = raw_parity[h*16 +: HALF_W];
    end

    // Inversion makes an erased sector produce an all-ones code.
    assign calc_code = ~packed_code;

endmodule

// File: rtl/ecc_syndrome_classify.sv
// Compares computed and stored code and sorts the syndrome into a class.
// Assumes the upper code half holds {byte offset, bit index} of a data
// fault and the lower half its complement. Purely combinational.
module ecc_syndrome_classify
    import nand_ecc_pkg::*;
#(
    parameter int HALF_W       = 12,
    parameter int SECTOR_BYTES = 512,
    localparam int CODE_W      = 2 * HALF_W,
    localparam int OFFS_W      = HALF_W - 3
) (
    input  logic [CODE_W-1:0] calc_code,
    input  logic [CODE_W-1:0] stored_code,
    output ecc_status_e       cls,
    output logic [OFFS_W-1:0] offset,
    output logic [7:0]        mask
);

    logic [CODE_W-1:0] syndrome;
    logic              is_compl;
    logic              in_range;
    logic              one_bit;

    assign syndrome = calc_code ^ stored_code;

    // Decode fault location from the upper syndrome half.
    always_comb begin
        offset = syndrome[CODE_W-1 -: OFFS_W];
        mask   = 8'(1) << syndrome[HALF_W +: 3];
    end

    // Derive the three tests the class decision needs.
    always_comb begin
        is_compl = (syndrome[HALF_W-1:0] ^ syndrome[CODE_W-1:HALF_W]) == '1;
        in_range = int'(offset) < SECTOR_BYTES;
        one_bit  = $countones(syndrome) == 1;
    end

    // Pick the class in order: clean, data fault, code fault, failure.
    always_comb begin
        if (syndrome == '0) begin
            cls = ECC_CLEAN;
        end else if (is_compl) begin
            cls = in_range ? ECC_DATA_FIXED : ECC_FAILED;
        end else if (one_bit) begin
            cls = ECC_CODE_ONLY;
        end else begin
            cls = ECC_FAILED;
        end
    end

endmodule

// File: rtl/ecc_rmw_seq.sv
// Latches a classification on start and, for a data fault, runs a
// read-modify-write of the faulty byte. Assumes the buffer returns read
// data one cycle after the read strobe. Start is taken only when idle.
module ecc_rmw_seq
    import nand_ecc_pkg::*;
#(
    parameter int OFFS_W       = 9,
    parameter int SECTOR_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  ecc_status_e       cls_in,
    input  logic [OFFS_W-1:0] offset_in,
    input  logic [7:0]        mask_in,
    input  logic [7:0]        buf_rdata,
    output logic              busy,
    output logic              done,
    output ecc_status_e       status_q,
    output logic [OFFS_W-1:0] offset_q,
    output logic [7:0]        mask_q,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [OFFS_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_e;

    seq_state_e state;

    // Advance the sequence and capture the result on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            status_q <= ECC_CLEAN;
            offset_q <= '0;
            mask_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        status_q <= cls_in;
                        offset_q <= offset_in;
                        mask_q   <= mask_in;
                        state    <= (cls_in == ECC_DATA_FIXED) ? ST_READ : ST_FIN;
                    end
                end
                ST_READ:  state <= ST_WRITE;
                ST_WRITE: state <= ST_FIN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Drive the handshake and buffer port from the current state.
    always_comb begin
        busy      = (state == ST_READ) || (state == ST_WRITE);
        done      = (state == ST_FIN);
        buf_rd_en = (state == ST_READ);
        buf_wr_en = (state == ST_WRITE);
        buf_addr  = offset_q;
        buf_wdata = buf_rdata ^ mask_q;
    end

    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(buf_rd_en)); // R6
    AST_RD_ONLY_ON_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> status_q == ECC_DATA_FIXED); // R8
    AST_OFFSET_IN_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        status_q == ECC_DATA_FIXED |-> int'(offset_q) < SECTOR_BYTES); // R7
    AST_MASK_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        status_q == ECC_DATA_FIXED |-> $countones(mask_q) == 1); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(status_q) && $stable(offset_q)); // R10

endmodule

// File: rtl/nand_ecc_corrector.sv
// Top level: packs the raw parity, classifies the syndrome against the
// stored code and repairs a single data bit in the sector buffer.
// Assumes stored_ecc holds byte 0 of the stored code in bits 7:0.
module nand_ecc_corrector
    import nand_ecc_pkg::*;
#(
    parameter int ECC_BYTES    = 3,
    parameter int SECTOR_BYTES = 512,
    localparam int CODE_W      = 8 * ECC_BYTES,
    localparam int HALF_W      = CODE_W / 2,
    localparam int OFFS_W      = HALF_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       raw_parity,
    input  logic [CODE_W-1:0] stored_ecc,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [OFFS_W-1:0] err_offset,
    output logic [7:0]        err_mask,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [OFFS_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);

    logic [CODE_W-1:0] calc_code;
    logic [CODE_W-1:0] stored_code;
    ecc_status_e       cls;
    ecc_status_e       status_q;
    logic [OFFS_W-1:0] offset_c;
    logic [7:0]        mask_c;

    // Reassemble the stored code from its bytes, least significant first.
    for (genvar b = 0; b < ECC_BYTES; b++) begin : g_byte
        assign stored_code[b*8 +: 8] = stored_ecc[b*8 +: 8];
    end

    ecc_code_pack #(.HALF_W(HALF_W)) u_pack (
        .raw_parity (raw_parity),
        .calc_code  (calc_code)
    );

    ecc_syndrome_classify #(.HALF_W(HALF_W), .SECTOR_BYTES(SECTOR_BYTES)) u_cls (
        .calc_code   (calc_code),
        .stored_code (stored_code),
        .cls         (cls),
        .offset      (offset_c),
        .mask        (mask_c)
    );

    ecc_rmw_seq #(.OFFS_W(OFFS_W), .SECTOR_BYTES(SECTOR_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cls_in    (cls),
        .offset_in (offset_c),
        .mask_in   (mask_c),
        .buf_rdata (buf_rdata),
        .busy      (busy),
        .done      (done),
        .status_q  (status_q),
        .offset_q  (err_offset),
        .mask_q    (err_mask),
        .buf_rd_en (buf_rd_en),
        .buf_wr_en (buf_wr_en),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata)
    );

    // Present the enumerated status on a plain port.
    assign status = status_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && status == 2'b00); // R1

endmodule

// File: tb/nand_ecc_corrector_tb.sv
module nand_ecc_corrector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] raw_parity = '0;
    logic [23:0] stored_ecc = '0;
    logic        busy, done, buf_rd_en, buf_wr_en;
    logic [1:0]  status;
    logic [8:0]  err_offset, buf_addr;
    logic [7:0]  err_mask, buf_wdata;
    logic [7:0]  buf_rdata = '0;
    logic [7:0]  mem [512];

    logic        s_busy, s_done, s_rd, s_wr;
    logic [1:0]  s_status;
    logic [8:0]  s_off, s_addr;
    logic [7:0]  s_mask, s_wdata;

    int tests = 0;
    int fails = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    nand_ecc_corrector #(.SECTOR_BYTES(512)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .raw_parity(raw_parity),
        .stored_ecc(stored_ecc), .busy(busy), .done(done), .status(status),
        .err_offset(err_offset), .err_mask(err_mask), .buf_rd_en(buf_rd_en),
        .buf_wr_en(buf_wr_en), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata)
    );

    // Smaller sector instance to reach the out-of-range offsets (R7).
    nand_ecc_corrector #(.SECTOR_BYTES(384)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .start(start), .raw_parity(raw_parity),
        .stored_ecc(stored_ecc), .busy(s_busy), .done(s_done), .status(s_status),
        .err_offset(s_off), .err_mask(s_mask), .buf_rd_en(s_rd),
        .buf_wr_en(s_wr), .buf_addr(s_addr), .buf_wdata(s_wdata),
        .buf_rdata(8'h00)
    );

    // Sector buffer model with one-cycle read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 37 + 5);
        end else begin
            if (buf_rd_en) buf_rdata <= mem[buf_addr];
            if (buf_wr_en) mem[buf_addr] <= buf_wdata;
        end
    end

    function automatic logic [23:0] calc_code(input logic [31:0] raw);
        return ~{raw[27:16], raw[11:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_raw();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    // One check run; exp_st 01 expects the repair sequence.
    task automatic run(input logic [31:0] raw, input logic [23:0] st,
                       input logic [1:0] exp_st, input logic [8:0] exp_off,
                       input logic [7:0] exp_mask, input string req);
        logic [7:0] orig;
        @(negedge clk);
        raw_parity = raw; stored_ecc = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (exp_st == 2'b01) begin
            orig = mem[exp_off];
            chk(busy && buf_rd_en && !done && buf_addr == exp_off, "R6 read cycle",
                {buf_rd_en, 7'd0, buf_addr}, {1'b1, 7'd0, exp_off});
            if (exp_off >= 384)
                chk(s_done && s_status == 2'b11 && !s_rd, "R7 offset beyond sector",
                    {30'd0, s_status}, 32'd3);
            else
                chk(s_rd && s_addr == exp_off, "R7 offset inside sector",
                    {23'd0, s_addr}, {23'd0, exp_off});
            @(negedge clk);
            chk(busy && buf_wr_en && buf_addr == exp_off && buf_wdata == (orig ^ exp_mask),
                "R6 write cycle", {buf_wr_en, 15'd0, buf_wdata}, {1'b1, 15'd0, orig ^ exp_mask});
            @(negedge clk);
            chk(done && !busy && !buf_rd_en && !buf_wr_en, "R6 done in cycle 3",
                {31'd0, done}, 32'd1);
            chk(status == 2'b01 && err_offset == exp_off && err_mask == exp_mask,
                "R5 location", {status, 13'd0, err_offset, err_mask},
                {2'b01, 13'd0, exp_off, exp_mask});
            chk(mem[exp_off] == (orig ^ exp_mask), "R6 buffer repaired",
                {24'd0, mem[exp_off]}, {24'd0, orig ^ exp_mask});
        end else begin
            chk(done && !busy && !buf_rd_en && status == exp_st, req,
                {done, busy, buf_rd_en, 27'd0, status}, {3'b100, 27'd0, exp_st});
        end
        @(negedge clk);
        chk(!done && !buf_rd_en && !buf_wr_en && status == exp_st, "R11 pulse and hold",
            {done, 29'd0, status}, {1'b0, 29'd0, exp_st});
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [11:0] h;
        logic [23:0] syn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 2'b00 && !busy && !done && !buf_rd_en && !buf_wr_en &&
            err_offset == 0 && err_mask == 0, "R1 reset state",
            {busy, done, buf_rd_en, buf_wr_en, 17'd0, err_offset, status}, 32'd0);

        // R4 erased sector: zero parity, all-ones stored code
        run(32'h0, 24'hFF_FFFF, 2'b00, 9'd0, 8'd0, "R4 erased sector clean");
        // R2 reserved nibbles have no effect
        for (int k = 0; k < 16; k++) begin
            next_raw();
            run(lfsr, calc_code(lfsr & 32'h0FFF_0FFF), 2'b00, 9'd0, 8'd0, "R2 reserved bits ignored");
        end

        // R5 R6 R3 every offset and bit of a data fault
        for (int off = 0; off < 512; off++) begin
            for (int b = 0; b < 8; b++) begin
                next_raw();
                h   = {off[8:0], b[2:0]};
                syn = {h, ~h};
                run(lfsr, calc_code(lfsr) ^ syn, 2'b01, off[8:0], 8'(1) << b, "R5 data fault");
            end
        end

        // R8 single-bit fault in the stored code (R3 byte lanes)
        for (int b = 0; b < 24; b++) begin
            next_raw();
            run(lfsr, calc_code(lfsr) ^ (24'd1 << b), 2'b10, 9'd0, 8'd0, "R8 code-only fault");
        end

        // R9 every two-bit fault
        for (int i = 0; i < 24; i++) begin
            for (int j = i + 1; j < 24; j++) begin
                next_raw();
                run(lfsr, calc_code(lfsr) ^ (24'd1 << i) ^ (24'd1 << j), 2'b11,
                    9'd0, 8'd0, "R9 uncorrectable");
            end
        end

        // R10 start during busy is ignored
        begin
            logic [7:0] orig;
            next_raw();
            h = {9'd10, 3'd2};
            orig = mem[10];
            @(negedge clk);
            raw_parity = lfsr; stored_ecc = calc_code(lfsr) ^ {h, ~h}; start = 1'b1;
            @(negedge clk);
            raw_parity = 32'h0; stored_ecc = 24'hFF_FFFF;
            @(negedge clk);
            chk(buf_wr_en && buf_addr == 9'd10, "R10 start while busy",
                {23'd0, buf_addr}, 32'd10);
            @(negedge clk);
            start = 1'b0;
            chk(done && status == 2'b01 && err_offset == 9'd10, "R10 result kept",
                {30'd0, status}, 32'd1);
            @(negedge clk);
            chk(!done && !busy && status == 2'b01 && mem[10] == (orig ^ 8'h04),
                "R10 start during done ignored", {24'd0, mem[10]}, {24'd0, orig ^ 8'h04});
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule